// File: doc/BRIEF.md
# Metaframe Lock Synchronizer

This block watches a word-aligned receive lane that delivers 64-bit words, each with a control tag. It finds the metaframe boundary and tells the logic downstream when the lane can be trusted. A metaframe is `MF_LEN` words long. Position 0 holds the synchronization word and position 1 holds the scrambler-state word. Both are control words, and each is recognized by a fixed type field in bits [63:58].

The block is a three-state machine.

- **HUNT** waits for any sync word. That word fixes the metaframe phase.
- **VERIFY** checks for a sync word at every later position 0. It declares lock once enough consecutive sync words have been seen.
- **LOCKED** no longer checks sync words. It checks the scrambler-state word at position 1 and gives up lock after enough consecutive bad ones.

Its outputs are the lock flag, a metaframe-start marker that marks the current input word, and the position that the current input word takes inside the metaframe.

The transitions are:

- `hunt_phase`: HUNT to VERIFY, taken on a sync word.
- `verify_hit`: VERIFY to VERIFY, taken on a sync word before the hit threshold.
- `verify_lock`: VERIFY to LOCKED, taken on the sync word that reaches the hit threshold.
- `verify_miss`: VERIFY to HUNT, taken on a non-sync word at position 0.
- `locked_keep`: LOCKED to LOCKED, taken on a good scrambler-state word, or on a bad one below the loss threshold.
- `locked_loss`: LOCKED to HUNT, taken on the bad scrambler-state word that reaches the loss threshold.

Top module: `mfsync_lock`

## Requirements
- R1: After reset, `lock_o` is 0, `word_pos_o` is 0 and the block is in HUNT.
- R2: In HUNT, `word_pos_o` stays 0 until a valid sync word arrives. A sync word has `in_ctrl`=1 and bits [63:58] equal to `SYNC_TYPE`. That word takes position 0, so the next valid word is at position 1.
- R3: Outside HUNT, each valid word advances `word_pos_o` by one, and the count wraps from `MF_LEN-1` to 0. Cycles with `in_valid`=0 leave the position and the state unchanged.
- R4: `lock_o` rises on the clock edge that accepts the `LOCK_HITS`-th sync word (default 4) in consecutive metaframes. The count includes the word that fixed the phase.
- R5: In VERIFY, a valid non-sync word at position 0 sends the block back to HUNT with position 0. The hit count is cleared, so `LOCK_HITS` fresh sync words are needed again.
- R6: In LOCKED, the word at position 0 is not checked, and a missing sync word does not affect lock.
- R7: In LOCKED, `LOSS_MISSES` consecutive bad scrambler-state words (default 3) at position 1 drop `lock_o` on the edge that accepts the last one. The block then returns to HUNT with position 0.
- R8: In LOCKED, a good scrambler-state word clears the count of bad ones.
- R9: A scrambler-state word is good only if `in_ctrl`=1 and bits [63:58] equal `SCRAM_TYPE`. Bits [57:0] are ignored. A word whose type field matches but whose `in_ctrl`=0 is neither a sync word nor a good scrambler-state word.
- R10: `frame_start_o` is high when a valid word is at position 0 outside HUNT, or when a valid sync word is present in HUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is present this cycle |
| in_ctrl | input | 1 | Control tag of the input word |
| in_data | input | 64 | Input word |
| lock_o | output | 1 | Metaframe lock |
| frame_start_o | output | 1 | Current input word opens a metaframe |
| word_pos_o | output | $clog2(MF_LEN) | Position the current input word takes |

## Verification
The hardest situation to reach from the ports is loss of lock. It depends on a run of bad scrambler-state words landing exactly at position 1, and each one is a whole metaframe apart. It also depends on that run not being broken by a good word. The bench builds complete metaframes through one task whose position-1 word can be good, carry the wrong type, or carry the right type with the control tag cleared. It interleaves these to show that a good word resets the run, and then samples lock on the exact edge of the third bad word. A second hard case is a broken hit run in VERIFY. This is reached by sending two good metaframes and then withholding the sync word. The bench then confirms that three further metaframes still do not give lock.

// File: rtl/mfsync_pkg.sv
package mfsync_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } sync_state_e;
endpackage

// File: rtl/mfsync_classify.sv
module mfsync_classify #(
    parameter int          DATA_W     = 64,
    parameter int          TYPE_W     = 6,
    parameter logic [5:0]  SYNC_TYPE  = 6'h1E,
    parameter logic [5:0]  SCRAM_TYPE = 6'h2D
) (
    input  logic              in_ctrl,
    input  logic [DATA_W-1:0] in_data,
    output logic              is_sync,
    output logic              is_scram
);
    logic [TYPE_W-1:0] type_field;
    logic              unused_payload;

    assign type_field     = in_data[DATA_W-1 -: TYPE_W];
    // The scrambler state payload plays no part in matching.
    assign unused_payload = ^in_data[DATA_W-TYPE_W-1:0];

    always_comb begin
        is_sync  = in_ctrl && (type_field == SYNC_TYPE[TYPE_W-1:0]);
        is_scram = in_ctrl && (type_field == SCRAM_TYPE[TYPE_W-1:0]);
    end

    // R9: both classes require the control tag
    always_comb begin
        a_r9_ctrl_needed: assert (in_ctrl || (!is_sync && !is_scram));
    end
endmodule

// File: rtl/mfsync_poscnt.sv
module mfsync_poscnt #(
    parameter int MF_LEN = 16,
    localparam int POS_W = $clog2(MF_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             clear,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(MF_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pos <= '0;
        end else if (step) begin
            pos <= (pos == POS_LAST) ? '0 : pos + 1'b1;
        end
    end

    // R3: position never leaves the metaframe
    a_r3_pos_range: assert property (@(posedge clk) disable iff (rst)
        pos <= POS_LAST);
    // R3: wrap from the last slot back to zero
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && pos == POS_LAST) |=> pos == '0);
endmodule

// File: rtl/mfsync_lock.sv
module mfsync_lock
    import mfsync_pkg::*;
#(
    parameter int          MF_LEN      = 16,
    parameter int          LOCK_HITS   = 4,
    parameter int          LOSS_MISSES = 3,
    parameter logic [5:0]  SYNC_TYPE   = 6'h1E,
    parameter logic [5:0]  SCRAM_TYPE  = 6'h2D
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic                      in_ctrl,
    input  logic [63:0]               in_data,
    output logic                      lock_o,
    output logic                      frame_start_o,
    output logic [$clog2(MF_LEN)-1:0] word_pos_o
);
    localparam int POS_W  = $clog2(MF_LEN);
    localparam int HIT_W  = $clog2(LOCK_HITS + 1);
    localparam int MISS_W = $clog2(LOSS_MISSES + 1);
    localparam logic [POS_W-1:0]  SYNC_POS  = '0;
    localparam logic [POS_W-1:0]  SCRAM_POS = POS_W'(1);
    localparam logic [HIT_W-1:0]  HIT_LAST  = HIT_W'(LOCK_HITS - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_MISSES - 1);

    sync_state_e       state_q, state_d;
    logic [HIT_W-1:0]  hits_q, hits_d;
    logic [MISS_W-1:0] miss_q, miss_d;
    logic              is_sync, is_scram;
    logic              pos_step, pos_clear;
    logic [POS_W-1:0]  pos;

    mfsync_classify #(
        .DATA_W(64), .TYPE_W(6),
        .SYNC_TYPE(SYNC_TYPE), .SCRAM_TYPE(SCRAM_TYPE)
    ) i_classify (
        .in_ctrl (in_ctrl),
        .in_data (in_data),
        .is_sync (is_sync),
        .is_scram(is_scram)
    );

    mfsync_poscnt #(.MF_LEN(MF_LEN)) i_poscnt (
        .clk  (clk),
        .rst  (rst),
        .step (pos_step),
        .clear(pos_clear),
        .pos  (pos)
    );

    // State and counter register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            hits_q  <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            hits_q  <= hits_d;
            miss_q  <= miss_d;
        end
    end

    // Transitions
    always_comb begin
        state_d   = state_q;
        hits_d    = hits_q;
        miss_d    = miss_q;
        pos_step  = 1'b0;
        pos_clear = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (in_valid && is_sync) begin      // hunt_phase
                    state_d  = ST_VERIFY;
                    hits_d   = HIT_W'(1);
                    pos_step = 1'b1;
                end
            end
            ST_VERIFY: begin
                if (in_valid) begin
                    pos_step = 1'b1;
                    if (pos == SYNC_POS) begin
                        if (!is_sync) begin         // verify_miss
                            state_d   = ST_HUNT;
                            hits_d    = '0;
                            pos_step  = 1'b0;
                            pos_clear = 1'b1;
                        end else if (hits_q == HIT_LAST) begin // verify_lock
                            state_d = ST_LOCKED;
                            hits_d  = '0;
                            miss_d  = '0;
                        end else begin              // verify_hit
                            hits_d = hits_q + 1'b1;
                        end
                    end
                end
            end
            ST_LOCKED: begin
                if (in_valid) begin
                    pos_step = 1'b1;
                    if (pos == SCRAM_POS) begin
                        if (is_scram) begin         // locked_keep
                            miss_d = '0;
                        end else if (miss_q == MISS_LAST) begin // locked_loss
                            state_d   = ST_HUNT;
                            miss_d    = '0;
                            pos_step  = 1'b0;
                            pos_clear = 1'b1;
                        end else begin              // locked_keep
                            miss_d = miss_q + 1'b1;
                        end
                    end
                end
            end
            default: begin
                state_d   = ST_HUNT;
                pos_clear = 1'b1;
            end
        endcase
    end

    // Outputs
    always_comb begin
        lock_o        = (state_q == ST_LOCKED);
        word_pos_o    = pos;
        frame_start_o = in_valid && (pos == SYNC_POS) &&
                        ((state_q != ST_HUNT) || is_sync);
    end

    // R1: reset leaves HUNT at slot zero
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (state_q == ST_HUNT && pos == '0));
    // R2: position is pinned at zero while hunting
    a_r2_hunt_pos: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_HUNT |-> pos == '0);
    // R3: idle cycles change nothing
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(pos) && $stable(state_q)));
    // R4: lock is only entered from VERIFY
    a_r4_lock_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> $past(state_q) == ST_VERIFY);
    // R7: lock is only left at the scrambler-state slot
    a_r7_loss_slot: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_o) |-> ($past(pos) == SCRAM_POS && pos == '0));
    // R8: a good scrambler-state word in LOCKED clears misses
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCKED && in_valid && pos == SCRAM_POS && is_scram)
        |=> miss_q == '0);
    // R10: the start marker only appears at slot zero
    a_r10_start_slot: assert property (@(posedge clk) disable iff (rst)
        frame_start_o |-> (pos == '0 && in_valid));
endmodule

// File: tb/test_mfsync_lock.sv
module test_mfsync_lock;
    localparam int         MF_LEN = 16;
    localparam logic [5:0] SYNC_T = 6'h1E;
    localparam logic [5:0] SCR_T  = 6'h2D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ctrl  = 1'b0;
    logic [63:0] in_data  = '0;
    logic        lock_o, frame_start_o;
    logic [3:0]  word_pos_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mfsync_lock i_mfsync_lock (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ctrl(in_ctrl),
        .in_data(in_data), .lock_o(lock_o), .frame_start_o(frame_start_o),
        .word_pos_o(word_pos_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic v, input logic c, input logic [63:0] d);
        @(negedge clk);
        in_valid = v; in_ctrl = c; in_data = d;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic word(input logic v, input logic c, input logic [63:0] d);
        put(v, c, d);
        tick();
    endtask

    // scr_mode: 0 good, 1 wrong type, 2 right type but data-tagged
    task automatic frame(input int first, input int last, input bit has_sync,
                         input int scr_mode, input logic [57:0] payload);
        for (int p = first; p <= last; p++) begin
            if (p == 0) begin
                if (has_sync) word(1'b1, 1'b1, {SYNC_T, 58'h1234});
                else          word(1'b1, 1'b0, {6'h05, 58'h77});
            end else if (p == 1) begin
                if (scr_mode == 0)      word(1'b1, 1'b1, {SCR_T, payload});
                else if (scr_mode == 1) word(1'b1, 1'b1, {6'h03, payload});
                else                    word(1'b1, 1'b0, {SCR_T, payload});
            end else begin
                word(1'b1, 1'b0, {6'h05, 58'(p * 3 + 7)});
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 lock after reset", int'(lock_o), 0);
        chk("R1 pos after reset", int'(word_pos_o), 0);
    endtask

    task automatic t_hunt_and_lock();
        word(1'b1, 1'b0, {SYNC_T, 58'h1});
        chk("R9 data-tagged sync type ignored", int'(word_pos_o), 0);
        word(1'b1, 1'b1, {SCR_T, 58'h2});
        chk("R2 non-sync keeps hunting", int'(word_pos_o), 0);
        put(1'b1, 1'b1, {SYNC_T, 58'h3});
        chk("R10 start on hunt sync", int'(frame_start_o), 1);
        tick();
        chk("R2 phase set", int'(word_pos_o), 1);
        frame(1, 7, 1'b1, 0, 58'h5);
        word(1'b0, 1'b1, {SYNC_T, 58'h0});
        chk("R3 idle holds pos", int'(word_pos_o), 8);
        frame(8, 15, 1'b1, 0, 58'h5);
        chk("R3 wrap to zero", int'(word_pos_o), 0);
        put(1'b1, 1'b1, {SYNC_T, 58'h9});
        chk("R10 start in verify", int'(frame_start_o), 1);
        tick();
        frame(1, 15, 1'b1, 0, 58'h5);
        frame(0, 15, 1'b1, 0, 58'h5);
        chk("R4 no lock after three", int'(lock_o), 0);
        frame(0, 0, 1'b1, 0, 58'h5);
        chk("R4 lock on fourth sync", int'(lock_o), 1);
        frame(1, 15, 1'b1, 0, 58'h5);
    endtask

    task automatic t_sync_ignored();
        put(1'b1, 1'b0, {6'h05, 58'h77});
        chk("R10 start without sync when locked", int'(frame_start_o), 1);
        tick();
        frame(1, 15, 1'b0, 0, 58'h5);
        chk("R6 lock kept without sync", int'(lock_o), 1);
    endtask

    task automatic t_miss_clear_loss();
        frame(0, 15, 1'b1, 1, 58'h5);
        frame(0, 15, 1'b1, 2, 58'h5);
        chk("R9 tagless scrambler word is a miss, lock kept", int'(lock_o), 1);
        frame(0, 15, 1'b1, 0, 58'h3FF_FFFF_FFFF);
        frame(0, 15, 1'b1, 1, 58'h5);
        frame(0, 15, 1'b1, 1, 58'h5);
        chk("R8 good word cleared misses", int'(lock_o), 1);
        frame(0, 0, 1'b1, 1, 58'h5);
        chk("R7 lock before third miss", int'(lock_o), 1);
        frame(1, 1, 1'b1, 1, 58'h5);
        chk("R7 lock lost on third miss", int'(lock_o), 0);
        chk("R7 pos reset on loss", int'(word_pos_o), 0);
        frame(2, 15, 1'b1, 0, 58'h5);
        chk("R2 data words keep hunting", int'(word_pos_o), 0);
    endtask

    task automatic t_verify_miss();
        frame(0, 15, 1'b1, 0, 58'h5);
        frame(0, 15, 1'b1, 0, 58'h5);
        frame(0, 0, 1'b0, 0, 58'h5);
        chk("R5 miss returns pos", int'(word_pos_o), 0);
        chk("R5 no lock after miss", int'(lock_o), 0);
        frame(0, 15, 1'b1, 0, 58'h5);
        frame(0, 15, 1'b1, 0, 58'h5);
        frame(0, 15, 1'b1, 0, 58'h5);
        chk("R5 hit count restarted", int'(lock_o), 0);
        frame(0, 0, 1'b1, 0, 58'h5);
        chk("R5 lock after fresh run", int'(lock_o), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_hunt_and_lock();
        t_sync_ignored();
        t_miss_clear_loss();
        t_verify_miss();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=1 exp=0");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule